// File: doc/BRIEF.md
# Four-Bit Two's-Complement Adder/Subtractor

This block takes two operand vectors and a single operation select and returns their sum or difference. One select bit does two jobs at once. It inverts every bit of the second operand through an XOR stage, and it drives the carry into the lowest cell, so that subtraction becomes addition of the two's complement.

The result comes from a ripple chain of identical full-adder cells. The carry leaving each cell is the carry entering the next. The block reports the raw carry from the top cell. It also reports a signed overflow flag, which is taken as the XOR of the carries entering and leaving the sign position. The block is purely combinational, so a surrounding datapath can register the outputs wherever its timing requires.

Top module: `addsub_ripple`

## Requirements
- R1: With `op_sub` = 0, `res` equals (`opa` + `opb`) mod 16, with both operands read as unsigned.
- R2: With `op_sub` = 1, `res` equals (`opa` − `opb`) mod 16, with both operands read as unsigned.
- R3: With `op_sub` = 0, `cout` equals bit 4 of the unsigned 5-bit sum `opa` + `opb`.
- R4: With `op_sub` = 1, `cout` is 1 exactly when `opa` ≥ `opb`, with both operands read as unsigned.
- R5: `ovf` is 1 exactly when the true signed result lies outside −8..7. The operands are read as two's complement, so bit 3 is the sign.
- R6: `ovf` can be 1 only in two cases: an add with operands whose sign bits match, or a subtract with operands whose sign bits differ.
- R7: When `ovf` is 1, bit 3 of `res` is the opposite of the sign of the true result. Two positive addends give a negative `res`, and two negative addends give a non-negative `res`.
- R8: The outputs depend only on the present inputs, and all-zero inputs give `res` = 0, `cout` = 0 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | First operand (minuend in subtract) |
| opb | input | 4 | Second operand (subtrahend in subtract) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| res | output | 4 | Sum or difference, low four bits |
| cout | output | 1 | Carry out of the top cell |
| ovf | output | 1 | Signed overflow flag |

## Verification
Several checks are evaluated on every settled input change, each against arithmetic written independently of the ripple chain:
- the result modulo 16;
- the meaning of the carry in subtract mode, where it signals no unsigned borrow;
- the condition on operand signs under which overflow may occur;
- the inverted sign bit whenever overflow is flagged.

The exact overflow decision (R5) and the add-mode carry (R3) come from the bench. It sweeps all 512 combinations of operands and mode against a signed reference model. It then applies random vectors from a fixed seed and directed corners such as −8 − 1, 7 + 1 and −8 + −8.

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         op_sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);

  logic [W:0]   cy;
  logic [W-1:0] bx;

  assign cy[0] = op_sub;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic gen, prop;
    assign bx[i]    = opb[i] ^ op_sub;
    assign gen      = opa[i] & bx[i];
    assign prop     = opa[i] ^ bx[i];
    assign res[i]   = prop ^ cy[i];
    assign cy[i+1]  = gen | (prop & cy[i]);
  end

  assign cout = cy[W];
  assign ovf  = cy[W] ^ cy[W-1];

  logic [W:0] ref_wide;
  assign ref_wide = op_sub ? ({1'b0, opa} - {1'b0, opb}) : ({1'b0, opa} + {1'b0, opb});

  always_comb begin
    if (!$isunknown({opa, opb, op_sub})) begin
      p_result_r1: assert (res == ref_wide[W-1:0]);
      if (op_sub) begin
        p_borrow_r4: assert (cout == (opa >= opb));
      end
      if (ovf) begin
        p_sign_cond_r6: assert (op_sub ? (opa[W-1] != opb[W-1]) : (opa[W-1] == opb[W-1]));
        p_sign_flip_r7: assert (res[W-1] != opa[W-1]);
      end
      if ({opa, opb, op_sub} == '0) begin
        p_zero_r8: assert (res == '0 && !cout && !ovf);
      end
    end
  end

endmodule

// File: tb/addsub_ripple_bench.sv
module addsub_ripple_bench;

  logic       clk = 1'b0;
  logic [3:0] opa = '0, opb = '0;
  logic       op_sub = 1'b0;
  logic [3:0] res;
  logic       cout, ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addsub_ripple u_addsub_ripple (
    .opa(opa), .opb(opb), .op_sub(op_sub),
    .res(res), .cout(cout), .ovf(ovf)
  );

  function automatic int sval(input logic [3:0] v);
    return (v >= 8) ? int'(v) - 16 : int'(v);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d", tag, opa, opb, op_sub, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic m);
    int ua, ub, us, sr, eres, ecout, eovf;
    @(posedge clk);
    opa = a; opb = b; op_sub = m;
    @(negedge clk);
    ua = int'(a); ub = int'(b);
    us = m ? (ua - ub) : (ua + ub);
    sr = m ? (sval(a) - sval(b)) : (sval(a) + sval(b));
    eres = us & 15;
    eovf = (sr > 7 || sr < -8) ? 1 : 0;
    if (m) begin
      chk("R2", int'(res), eres);
      ecout = (ua >= ub) ? 1 : 0;
      chk("R4", int'(cout), ecout);
    end else begin
      chk("R1", int'(res), eres);
      ecout = (us >> 4) & 1;
      chk("R3", int'(cout), ecout);
    end
    chk("R5", int'(ovf), eovf);
    if (ovf) begin
      chk("R6", (m ? (a[3] != b[3]) : (a[3] == b[3])) ? 1 : 0, 1);
      chk("R7", int'(res[3]), (sr < 0) ? 0 : 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = 1234;
    r = $urandom(seed);
    @(negedge clk);
    chk("R8 res", int'(res), 0);
    chk("R8 cout", int'(cout), 0);
    chk("R8 ovf", int'(ovf), 0);
    apply(4'h8, 4'h1, 1'b1);
    chk("R5 -8-1", int'(ovf), 1);
    apply(4'h7, 4'h1, 1'b0);
    chk("R7 7+1", int'(res), 8);
    apply(4'h8, 4'h8, 1'b0);
    chk("R3 -8+-8", int'(cout), 1);
    apply(4'h0, 4'h0, 1'b1);
    chk("R4 0-0", int'(cout), 1);
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(4'(a), 4'(b), 1'(m));
    for (int k = 0; k < 300; k++) begin
      r = $urandom;
      apply(r[3:0], r[7:4], r[8]);
    end
    apply(4'h0, 4'h0, 1'b0);
    chk("R8 zero again", int'({res, cout, ovf}), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule